// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves one 128-bit quadword from memory to an outbound stream. Software programs it through a small register port: a control word holding a start flag, a source memory address, a quadword count and a tag address. All of these read back as written. When software raises the start flag while the engine is idle, the engine requests a read at the programmed address. It waits for the returned quadword, captures it, offers it on a valid/ready send port, and then finishes.

Completion is visible without any interrupt, in two ways. The start flag drops by itself once the transfer is over. A read-only completion counter also steps by one for every finished transfer, so software can compare the counter before and after. The sequence of phases is idle, fetch-wait, send, done and back to idle. The quadword count is stored but only single-quadword transfers are performed.

Top module: `dma1_engine`

## Requirements
- R1: After reset every register reads zero, the completion counter reads zero, and `mem_req`, `snd_valid` and `cfg_rd_valid` are low.
- R2: Writes to offset 0x00 (control), 0x10 (memory address), 0x20 (quadword count) and 0x30 (tag address) are stored as full 32-bit values and read back unchanged while the engine is idle.
- R3: `cfg_rd_valid` is high exactly in the cycle after a cycle with `cfg_rd_en` high, with `cfg_rd_data` holding the register value from the `cfg_rd_en` cycle. Any offset other than 0x00, 0x10, 0x20, 0x30 and 0x40 reads zero. Writes to 0x40 or to unmapped offsets change nothing.
- R4: If bit 8 of the control register is set while idle, `mem_req` rises in the next cycle with `mem_addr` equal to the memory address register. `mem_req` stays high until a cycle with `mem_rsp_valid` high, and a response in the first request cycle is accepted.
- R5: The data present with `mem_rsp_valid` during a request is captured, and `snd_valid` rises in the next cycle carrying exactly that data. `mem_rsp_valid` while no request is open has no effect.
- R6: `snd_valid` and `snd_data` hold steady until a cycle with `snd_ready` high, and `snd_valid` is low in the following cycle.
- R7: The completion counter at offset 0x40 increases by exactly one, modulo 2^32, in the cycle after each send handshake, and never changes otherwise.
- R8: Bit 8 of the control register is cleared two cycles after the send handshake, when the engine returns to idle. The other control bits keep their written values.
- R9: While a transfer is in progress, a control write updates every bit except bit 8, which stays set until the engine clears it.
- R10: `mem_req` and `snd_valid` are never high together. Each start produces exactly one request phase and one send phase. A control write with bit 8 clear while idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_off | input | 8 | Register write offset |
| cfg_wr_data | input | 32 | Register write value |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_off | input | 8 | Register read offset |
| cfg_rd_data | output | 32 | Read result, valid one cycle after the strobe |
| cfg_rd_valid | output | 1 | Marks the cycle carrying a read result |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 128 | Memory read quadword |
| snd_valid | output | 1 | Outbound quadword valid |
| snd_data | output | 128 | Outbound quadword |
| snd_ready | input | 1 | Outbound sink accepts |

## Verification
The assertions assume that the memory side raises `mem_rsp_valid` only as an answer to an open request, and that software does not rewrite the memory address register while a transfer runs. Only under these assumptions do the captured data and the request address have a single meaning. The stimulus keeps to this: it answers each request once, after a random delay of zero to four cycles. The only response it drives outside a request is a deliberate idle pulse whose lack of effect is then checked. Control writes during a transfer happen only in the fetch-wait phase, and they always carry bit 8 clear.

// File: rtl/dma1_pkg.sv
package dma1_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_e;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MADR = 'h10;
  localparam int OFF_QCNT = 'h20;
  localparam int OFF_TAGA = 'h30;
  localparam int OFF_DCNT = 'h40;

  localparam int START_BIT = 8;

endpackage

// File: rtl/dma1_regs.sv
module dma1_regs
  import dma1_pkg::*;
#(
  parameter int REGW = 32,
  parameter int OFFW = 8,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [OFFW-1:0] wr_off,
  input  logic [REGW-1:0] wr_data,
  input  logic            rd_en,
  input  logic [OFFW-1:0] rd_off,
  input  logic            busy,
  input  logic            clr_start,
  input  logic            done_evt,
  output logic [REGW-1:0] rd_data,
  output logic            rd_valid,
  output logic            start_req,
  output logic [REGW-1:0] madr,
  output logic [CNTW-1:0] done_cnt
);

  localparam logic [REGW-1:0] START_MASK = REGW'(1) << START_BIT;

  logic [REGW-1:0] ctrl_q, ctrl_d;
  logic [REGW-1:0] madr_q, qcnt_q, taga_q;
  logic [CNTW-1:0] cnt_q;
  logic [REGW-1:0] rd_data_q;
  logic            rd_valid_q;

  // Control update: the launch flag is protected while a transfer runs.
  function automatic logic [REGW-1:0] ctrl_merge(input logic [REGW-1:0] old_v,
                                                 input logic [REGW-1:0] new_v,
                                                 input logic            keep);
    return keep ? ((new_v & ~START_MASK) | (old_v & START_MASK)) : new_v;
  endfunction

  function automatic logic hit(input logic [OFFW-1:0] off, input int target);
    return off == OFFW'(target);
  endfunction

  function automatic logic [REGW-1:0] pick(input logic [OFFW-1:0] off);
    logic [REGW-1:0] v;
    v = '0;
    if (hit(off, OFF_CTRL)) v = ctrl_q;
    if (hit(off, OFF_MADR)) v = madr_q;
    if (hit(off, OFF_QCNT)) v = qcnt_q;
    if (hit(off, OFF_TAGA)) v = taga_q;
    if (hit(off, OFF_DCNT)) v = REGW'(cnt_q);
    return v;
  endfunction

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && hit(wr_off, OFF_CTRL)) ctrl_d = ctrl_merge(ctrl_q, wr_data, busy);
    if (clr_start) ctrl_d = ctrl_d & ~START_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      madr_q     <= '0;
      qcnt_q     <= '0;
      taga_q     <= '0;
      cnt_q      <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_en && hit(wr_off, OFF_MADR)) madr_q <= wr_data;
      if (wr_en && hit(wr_off, OFF_QCNT)) qcnt_q <= wr_data;
      if (wr_en && hit(wr_off, OFF_TAGA)) taga_q <= wr_data;
      if (done_evt) cnt_q <= cnt_q + 1'b1;
      rd_valid_q <= rd_en;
      rd_data_q  <= rd_en ? pick(rd_off) : '0;
    end
  end

  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign start_req = ctrl_q[START_BIT];
  assign madr      = madr_q;
  assign done_cnt  = cnt_q;

endmodule

// File: rtl/dma1_xfer.sv
module dma1_xfer
  import dma1_pkg::*;
#(
  parameter int REGW = 32,
  parameter int AW   = 32,
  parameter int DW   = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic [REGW-1:0] base_addr,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  input  logic            snd_ready,
  output xfer_state_e     state,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic            snd_valid,
  output logic [DW-1:0]   snd_data,
  output logic            done_evt,
  output logic            clr_start,
  output logic            busy
);

  xfer_state_e st_q, st_d;
  logic [DW-1:0] hold_q;
  logic          take_rsp;

  assign take_rsp = (st_q == ST_FETCH) && rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_req) st_d = ST_FETCH;
      ST_FETCH: if (rsp_valid) st_d = ST_SEND;
      ST_SEND:  if (snd_ready) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (take_rsp) hold_q <= rsp_data;
    end
  end

  assign state     = st_q;
  assign mem_req   = (st_q == ST_FETCH);
  assign mem_addr  = AW'(base_addr);
  assign snd_valid = (st_q == ST_SEND);
  assign snd_data  = hold_q;
  assign done_evt  = (st_q == ST_SEND) && snd_ready;
  assign clr_start = (st_q == ST_DONE);
  assign busy      = (st_q != ST_IDLE);

endmodule

// File: rtl/dma1_engine.sv
module dma1_engine
  import dma1_pkg::*;
#(
  parameter int REGW = 32,
  parameter int OFFW = 8,
  parameter int AW   = 32,
  parameter int DW   = 128,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [OFFW-1:0] cfg_wr_off,
  input  logic [REGW-1:0] cfg_wr_data,
  input  logic            cfg_rd_en,
  input  logic [OFFW-1:0] cfg_rd_off,
  output logic [REGW-1:0] cfg_rd_data,
  output logic            cfg_rd_valid,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic            snd_valid,
  output logic [DW-1:0]   snd_data,
  input  logic            snd_ready
);

  // Named internal events, observed by the bound checker.
  xfer_state_e     st;
  logic            ctrl_start;
  logic            busy;
  logic            clr_start;
  logic            done_evt;
  logic [REGW-1:0] madr;
  logic [CNTW-1:0] done_cnt;

  dma1_regs #(.REGW(REGW), .OFFW(OFFW), .CNTW(CNTW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_off    (cfg_wr_off),
    .wr_data   (cfg_wr_data),
    .rd_en     (cfg_rd_en),
    .rd_off    (cfg_rd_off),
    .busy      (busy),
    .clr_start (clr_start),
    .done_evt  (done_evt),
    .rd_data   (cfg_rd_data),
    .rd_valid  (cfg_rd_valid),
    .start_req (ctrl_start),
    .madr      (madr),
    .done_cnt  (done_cnt)
  );

  dma1_xfer #(.REGW(REGW), .AW(AW), .DW(DW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (ctrl_start),
    .base_addr (madr),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .snd_ready (snd_ready),
    .state     (st),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .snd_valid (snd_valid),
    .snd_data  (snd_data),
    .done_evt  (done_evt),
    .clr_start (clr_start),
    .busy      (busy)
  );

endmodule

// File: rtl/dma1_engine_chk.sv
module dma1_engine_chk
  import dma1_pkg::*;
#(
  parameter int DW   = 128,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_rd_en,
  input logic            cfg_rd_valid,
  input logic            mem_req,
  input logic            mem_rsp_valid,
  input logic [DW-1:0]   mem_rsp_data,
  input logic            snd_valid,
  input logic            snd_ready,
  input logic [DW-1:0]   snd_data,
  input xfer_state_e     st,
  input logic            ctrl_start,
  input logic            busy,
  input logic            done_evt,
  input logic [CNTW-1:0] done_cnt
);

  p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |=> cfg_rd_valid);
  p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_en |=> !cfg_rd_valid);

  p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && ctrl_start) |=> mem_req);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> mem_req);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rsp_valid) |=> (snd_valid && snd_data == $past(mem_rsp_data)));

  p_send_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_data)));
  p_send_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && snd_ready) |=> !snd_valid);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (done_cnt == $past(done_cnt) + 1'b1));
  p_cnt_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> (done_cnt == $past(done_cnt)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> (!ctrl_start && st == ST_IDLE));

  p_busy_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != ST_DONE && ctrl_start) |=> ctrl_start);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && snd_valid));
  p_fetch_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |=> (st == ST_FETCH || st == ST_SEND));
  p_send_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND) |=> (st == ST_SEND || st == ST_DONE));
  p_idle_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (st == ST_IDLE || st == ST_FETCH));

endmodule

bind dma1_engine dma1_engine_chk #(.DW(DW), .CNTW(CNTW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rd_en     (cfg_rd_en),
  .cfg_rd_valid  (cfg_rd_valid),
  .mem_req       (mem_req),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .snd_valid     (snd_valid),
  .snd_ready     (snd_ready),
  .snd_data      (snd_data),
  .st            (st),
  .ctrl_start    (ctrl_start),
  .busy          (busy),
  .done_evt      (done_evt),
  .done_cnt      (done_cnt)
);

// File: tb/tb_dma1_engine.sv
`timescale 1ns/1ps
module tb_dma1_engine;

  localparam logic [7:0] A_CTRL = 8'h00, A_MADR = 8'h10, A_QCNT = 8'h20,
                         A_TAGA = 8'h30, A_DCNT = 8'h40;
  localparam logic [31:0] GO = 32'h0000_0100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr_en = 1'b0;
  logic [7:0]   cfg_wr_off = '0;
  logic [31:0]  cfg_wr_data = '0;
  logic         cfg_rd_en = 1'b0;
  logic [7:0]   cfg_rd_off = '0;
  logic [31:0]  cfg_rd_data;
  logic         cfg_rd_valid;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic         snd_valid;
  logic [127:0] snd_data;
  logic         snd_ready = 1'b0;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned seed_sink;
  bit          finished = 1'b0;

  // Software-side view of the register file.
  logic [31:0] m_ctrl, m_madr, m_qcnt, m_taga, m_cnt;

  always #4 clk = ~clk;

  dma1_engine dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_off(cfg_wr_off), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_en(cfg_rd_en), .cfg_rd_off(cfg_rd_off),
    .cfg_rd_data(cfg_rd_data), .cfg_rd_valid(cfg_rd_valid),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .snd_valid(snd_valid), .snd_data(snd_data), .snd_ready(snd_ready)
  );

  function automatic bit is_mapped(input logic [7:0] o);
    return o == A_CTRL || o == A_MADR || o == A_QCNT || o == A_TAGA || o == A_DCNT;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] o);
    case (o)
      A_CTRL:  return m_ctrl;
      A_MADR:  return m_madr;
      A_QCNT:  return m_qcnt;
      A_TAGA:  return m_taga;
      A_DCNT:  return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  // Control value seen after a busy-time write: new low/high bits, launch flag kept set.
  function automatic logic [31:0] busy_ctrl(input logic [31:0] w);
    return {w[31:9], 1'b1, w[7:0]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] o, input logic [31:0] v);
    cfg_wr_en = 1'b1; cfg_wr_off = o; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input string req, input logic [7:0] o, input logic [31:0] exp);
    cfg_rd_en = 1'b1; cfg_rd_off = o;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    chk(req, {127'b0, cfg_rd_valid}, 128'd1);
    chk(req, {96'b0, cfg_rd_data}, {96'b0, exp});
  endtask

  task automatic run_xfer(input logic [31:0] addr, input logic [127:0] q,
                          input int rsp_dly, input int rdy_dly,
                          input bit early_rdy, input bit mid_wr);
    logic [31:0] cw, w2;
    cw = ($urandom & ~GO) | GO;
    reg_write(A_MADR, addr); m_madr = addr;
    reg_write(A_CTRL, cw);
    chk("R4 idle before launch", {127'b0, mem_req}, 128'd0);
    @(negedge clk);
    chk("R4 request raised", {127'b0, mem_req}, 128'd1);
    chk("R4 request address", {96'b0, mem_addr}, {96'b0, addr});
    if (mid_wr) begin
      w2 = $urandom & ~GO;
      reg_write(A_CTRL, w2);
      cw = busy_ctrl(w2);
      reg_read("R9 busy write keeps start", A_CTRL, cw);
      chk("R4 request held", {127'b0, mem_req}, 128'd1);
    end
    for (int i = 0; i < rsp_dly; i++) begin
      chk("R4 request held", {127'b0, mem_req}, 128'd1);
      chk("R10 no send during fetch", {127'b0, snd_valid}, 128'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = q;
    if (early_rdy) snd_ready = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data = {$urandom, $urandom, $urandom, $urandom};
    chk("R5 send valid", {127'b0, snd_valid}, 128'd1);
    chk("R5 send data", snd_data, q);
    chk("R10 request dropped", {127'b0, mem_req}, 128'd0);
    if (!early_rdy) begin
      for (int i = 0; i < rdy_dly; i++) begin
        @(negedge clk);
        chk("R6 valid held", {127'b0, snd_valid}, 128'd1);
        chk("R6 data held", snd_data, q);
      end
      snd_ready = 1'b1;
    end
    @(negedge clk);
    snd_ready = 1'b0;
    chk("R6 valid dropped", {127'b0, snd_valid}, 128'd0);
    m_cnt = m_cnt + 32'd1;
    reg_read("R7 counter stepped", A_DCNT, m_cnt);
    m_ctrl = cw & ~GO;
    reg_read("R8 start cleared", A_CTRL, m_ctrl);
    chk("R10 single request", {126'b0, mem_req, snd_valid}, 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0]  o;
    logic [31:0] v;
    seed_sink = $urandom(32'd5813);
    m_ctrl = '0; m_madr = '0; m_qcnt = '0; m_taga = '0; m_cnt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 mem_req", {127'b0, mem_req}, 128'd0);
    chk("R1 snd_valid", {127'b0, snd_valid}, 128'd0);
    chk("R1 rd_valid", {127'b0, cfg_rd_valid}, 128'd0);
    reg_read("R1 ctrl", A_CTRL, 32'h0);
    reg_read("R1 madr", A_MADR, 32'h0);
    reg_read("R1 qcnt", A_QCNT, 32'h0);
    reg_read("R1 taga", A_TAGA, 32'h0);
    reg_read("R1 counter", A_DCNT, 32'h0);
    @(negedge clk);
    chk("R3 valid only after strobe", {127'b0, cfg_rd_valid}, 128'd0);

    // R2: random write/readback, launch flag kept clear
    for (int i = 0; i < 10; i++) begin
      v = $urandom;
      case ($urandom_range(0, 3))
        0: begin v = v & ~GO; reg_write(A_CTRL, v); m_ctrl = v; end
        1: begin reg_write(A_MADR, v); m_madr = v; end
        2: begin reg_write(A_QCNT, v); m_qcnt = v; end
        default: begin reg_write(A_TAGA, v); m_taga = v; end
      endcase
      reg_read("R2 readback ctrl", A_CTRL, m_ctrl);
      reg_read("R2 readback madr", A_MADR, m_madr);
      reg_read("R2 readback qcnt", A_QCNT, m_qcnt);
      reg_read("R2 readback taga", A_TAGA, m_taga);
    end
    chk("R10 no launch without bit 8", {127'b0, mem_req}, 128'd0);

    // R3: unmapped offsets read zero; writes there and to the counter are dropped
    for (int i = 0; i < 8; i++) begin
      o = 8'($urandom_range(0, 255));
      if (is_mapped(o)) o = 8'h44;
      reg_write(o, $urandom);
      reg_read("R3 unmapped reads zero", o, model_read(o));
    end
    reg_write(A_DCNT, 32'hDEAD_BEEF);
    reg_read("R3 counter not writable", A_DCNT, m_cnt);
    reg_read("R3 ctrl untouched", A_CTRL, m_ctrl);
    reg_read("R3 madr untouched", A_MADR, m_madr);

    // R10: idle write with bit 8 clear starts nothing
    v = $urandom & ~GO;
    reg_write(A_CTRL, v); m_ctrl = v;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 idle write no request", {127'b0, mem_req}, 128'd0);
    end

    // R5: response outside a request is ignored
    mem_rsp_valid = 1'b1; mem_rsp_data = {4{32'hA5A5_5A5A}};
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk("R5 stray response no send", {127'b0, snd_valid}, 128'd0);
    reg_read("R5 stray response no count", A_DCNT, m_cnt);

    // Directed corners: immediate response, ready raised early, busy write
    run_xfer(32'h0000_0000, {4{32'hFFFF_FFFF}}, 0, 0, 1'b0, 1'b0);
    run_xfer(32'hFFFF_FFF0, 128'h1, 0, 0, 1'b1, 1'b0);
    run_xfer(32'h1234_5670, {32'hCAFE_F00D, 96'h0}, 2, 3, 1'b0, 1'b1);
    reg_read("R2 madr after transfers", A_MADR, m_madr);

    // Random transfers
    for (int i = 0; i < 14; i++) begin
      run_xfer($urandom, {$urandom, $urandom, $urandom, $urandom},
               $urandom_range(0, 4), $urandom_range(0, 3),
               bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    reg_read("R7 final counter", A_DCNT, m_cnt);
    reg_read("R2 qcnt kept", A_QCNT, m_qcnt);
    reg_read("R2 taga kept", A_TAGA, m_taga);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule